// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block drives an 8-bit raw NAND flash bus from a small host register interface. A host write to the command register starts one byte cycle with the command-latch line raised. A write to the address register starts one byte cycle with the address-latch line raised. A write to the data register starts a write-strobe cycle. A read of the data register starts a read-strobe cycle, and the byte sampled from the bus is handed back on a separate result strobe.

Every bus cycle has three phases: a setup phase with the latch lines and write data in place, an active phase with the strobe held low, and a hold phase with the strobe released. The configuration register holds the length of each phase as a count minus one. It also holds a global enable bit and the active-low chip-enable bit.

The host polls a status register to see the flash ready/busy pin. A new bus access waits until the previous cycle has finished its hold phase. Register accesses are never held off.

Top module: `nand_seq_top`

## Requirements
- R1: After reset every strobe is high, CLE, ALE and the data drive enable are low, chip enable is high (deselected), `host_ready` is 1, and the configuration register reads 0x8B77.
- R2: In the configuration register (`host_addr` 0), bit 15 is the enable, bit 11 the chip-enable level, bits 9:8 the setup count minus one, bits 6:4 the active count minus one and bits 2:0 the hold count minus one. All other bits read 0, so writing 0xFFFF reads back 0x8B77.
- R3: A bus cycle lasts setup+1 cycles with the strobe high, then active+1 cycles with its strobe low, then hold+1 cycles with the strobe high. Only one strobe is ever low at a time.
- R4: A write to `host_addr` 1 runs one cycle with CLE high for all three phases, ALE low, and the low byte of the write data driven for all three phases.
- R5: A write to `host_addr` 2 runs one cycle with ALE high for all three phases and CLE low, driving the byte as in R4. CLE and ALE are never high together.
- R6: A write to `host_addr` 3 pulses `nand_we_n` with CLE and ALE low. The byte is driven with the drive enable high and stable from the first setup cycle to the last hold cycle.
- R7: A read of `host_addr` 3 pulses `nand_re_n` with the drive enable low. It captures `nand_dq_in` at the last active cycle and pulses `rd_valid` for one cycle, in the first hold cycle, with that byte on `rd_byte`.
- R8: `nand_ce_n` follows configuration bit 11 from the cycle after the write: 1 deselects the flash and 0 selects it.
- R9: Reading `host_addr` 4 returns `nand_rb` in bit 0, through a two-stage synchronizer (1 ready, 0 busy), with all other bits 0.
- R10: `host_ready` is 0 from the first setup cycle to the last hold cycle. While it is 0 a bus access is held off, a configuration or status access is still taken, and the bus lines are idle whenever it is 1.
- R11: A timing change written during a cycle leaves that cycle's phase lengths unchanged. The next cycle uses the new lengths.
- R12: With the enable bit clear, bus accesses are accepted and dropped. No strobe, CLE, ALE, drive enable or `rd_valid` activity follows, and `host_ready` stays 1.
- R13: With the reset timing values, a cycle lasts 4 setup, 8 active and 8 hold cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until taken |
| host_wr | input | 1 | 1 write, 0 read |
| host_addr | input | 3 | Register index: 0 cfg, 1 command, 2 address, 3 data, 4 status |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for cfg and status |
| host_ready | output | 1 | 1 when a bus access can be taken |
| rd_valid | output | 1 | One-cycle pulse: read byte available |
| rd_byte | output | 8 | Byte captured by the last read cycle |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus byte driven outward |
| nand_dq_oe | output | 1 | Drive enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Bus byte from the flash |
| nand_rb | input | 1 | Ready/busy pin, 1 ready |

## Verification
Faults in the phase counter or the shadow timing copy show up on the very cycle they occur. The bench measures each phase of each cycle and compares it with a length it works out itself, so a counter off by one shows as a shorter or longer strobe or hold on that cycle. A shadow that loads at the wrong time shows on the cycle in flight when the timing changes. A wrong operation code shows as the wrong latch line or drive enable in the first setup cycle. A phase register stuck away from idle shows as `host_ready` staying low, and the next bus access is never taken.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  localparam int REG_W  = 16;
  localparam int RIDX_W = 3;
  localparam int SU_W   = 2;
  localparam int PH_W   = 3;

  localparam int EN_POS  = 15;
  localparam int CE_POS  = 11;
  localparam int SU_POS  = 8;
  localparam int ACT_POS = 4;
  localparam int HLD_POS = 0;

  localparam logic [RIDX_W-1:0] RIX_CFG = 3'd0;
  localparam logic [RIDX_W-1:0] RIX_CMD = 3'd1;
  localparam logic [RIDX_W-1:0] RIX_ADR = 3'd2;
  localparam logic [RIDX_W-1:0] RIX_DAT = 3'd3;
  localparam logic [RIDX_W-1:0] RIX_STA = 3'd4;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;
  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_WRITE, OP_READ} op_e;

  typedef struct packed {
    logic [SU_W-1:0] su;
    logic [PH_W-1:0] act;
    logic [PH_W-1:0] hld;
  } timing_t;
endpackage

// File: rtl/nfs_regs.sv
module nfs_regs
  import nfs_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             rb_pin,
  output timing_t          tim,
  output logic             en,
  output logic             ce_n,
  output logic [REG_W-1:0] cfg_word,
  output logic             rb_ready
);
  localparam timing_t TIM_MAX = '1;

  timing_t          tim_q, tim_d;
  logic             en_q, en_d;
  logic             ce_q, ce_d;
  logic [SYNC_N-1:0] sy_q, sy_d;

  // bits with no function; the name keeps the lint quiet about them
  logic cfg_unused_bits;
  assign cfg_unused_bits = ^{cfg_wdata[14:12], cfg_wdata[10], cfg_wdata[7], cfg_wdata[3]};

  always_comb begin
    tim_d = tim_q;
    en_d  = en_q;
    ce_d  = ce_q;
    if (cfg_we) begin
      en_d      = cfg_wdata[EN_POS];
      ce_d      = cfg_wdata[CE_POS];
      tim_d.su  = cfg_wdata[SU_POS  +: SU_W];
      tim_d.act = cfg_wdata[ACT_POS +: PH_W];
      tim_d.hld = cfg_wdata[HLD_POS +: PH_W];
    end
    sy_d = {sy_q[SYNC_N-2:0], rb_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q <= TIM_MAX;
      en_q  <= 1'b1;
      ce_q  <= 1'b1;
      sy_q  <= '0;
    end else begin
      tim_q <= tim_d;
      en_q  <= en_d;
      ce_q  <= ce_d;
      sy_q  <= sy_d;
    end
  end

  always_comb begin
    cfg_word                     = '0;
    cfg_word[EN_POS]             = en_q;
    cfg_word[CE_POS]             = ce_q;
    cfg_word[SU_POS  +: SU_W]    = tim_q.su;
    cfg_word[ACT_POS +: PH_W]    = tim_q.act;
    cfg_word[HLD_POS +: PH_W]    = tim_q.hld;
  end

  assign tim      = tim_q;
  assign en       = en_q;
  assign ce_n     = ce_q;
  assign rb_ready = sy_q[SYNC_N-1];
endmodule

// File: rtl/nfs_phase.sv
module nfs_phase
  import nfs_pkg::*;
#(
  parameter int DQ_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  op_e             op_in,
  input  logic [DQ_W-1:0] byte_in,
  input  timing_t         tim,
  input  logic [DQ_W-1:0] dq_in,
  output phase_e          phase,
  output op_e             op,
  output logic [DQ_W-1:0] byte_out,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_byte
);
  localparam int CNT_W = (SU_W > PH_W) ? SU_W : PH_W;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  timing_t          tq;
  op_e              op_q;
  logic [DQ_W-1:0]  byte_q;
  logic             rdv_q, rdv_d;
  logic [DQ_W-1:0]  rdb_q, rdb_d;
  logic             ld_en;
  logic             cnt_zero;

  assign ld_en    = (ph_q == PH_IDLE) && launch;
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    rdv_d = 1'b0;
    rdb_d = rdb_q;
    case (ph_q)
      PH_IDLE: begin
        if (launch) begin
          ph_d  = PH_SETUP;
          cnt_d = CNT_W'(tim.su);
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          ph_d  = PH_STROBE;
          cnt_d = CNT_W'(tq.act);
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          ph_d  = PH_HOLD;
          cnt_d = CNT_W'(tq.hld);
          if (op_q == OP_READ) begin
            rdv_d = 1'b1;
            rdb_d = dq_in;
          end
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      PH_HOLD: begin
        if (cnt_zero) ph_d = PH_IDLE;
        else          cnt_d = cnt_q - CNT_ONE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      rdv_q <= 1'b0;
      rdb_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      rdv_q <= rdv_d;
      rdb_q <= rdb_d;
    end
  end

  // shadow copy of the operation and timing, loaded only at launch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tq     <= '0;
      op_q   <= OP_CMD;
      byte_q <= '0;
    end else if (ld_en) begin
      tq     <= tim;
      op_q   <= op_in;
      byte_q <= byte_in;
    end
  end

  assign phase    = ph_q;
  assign op       = op_q;
  assign byte_out = byte_q;
  assign rd_valid = rdv_q;
  assign rd_byte  = rdb_q;
endmodule

// File: rtl/nfs_pins.sv
module nfs_pins
  import nfs_pkg::*;
#(
  parameter int DQ_W = 8
) (
  input  phase_e          phase,
  input  op_e             op,
  input  logic [DQ_W-1:0] byte_in,
  output logic            cle,
  output logic            ale,
  output logic            we_n,
  output logic            re_n,
  output logic            dq_oe,
  output logic [DQ_W-1:0] dq_out
);
  logic active;
  logic strobe;

  always_comb begin
    active = (phase != PH_IDLE);
    strobe = (phase == PH_STROBE);
    cle    = active && (op == OP_CMD);
    ale    = active && (op == OP_ADDR);
    we_n   = !(strobe && (op != OP_READ));
    re_n   = !(strobe && (op == OP_READ));
    dq_oe  = active && (op != OP_READ);
    dq_out = dq_oe ? byte_in : '0;
  end
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nfs_pkg::*;
#(
  parameter int DQ_W   = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [RIDX_W-1:0] host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  output logic [REG_W-1:0]  host_rdata,
  output logic              host_ready,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_byte,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DQ_W-1:0]   nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DQ_W-1:0]   nand_dq_in,
  input  logic              nand_rb
);
  timing_t          tim;
  logic             en;
  logic [REG_W-1:0] cfg_word;
  logic             rb_ready;
  logic             cfg_we;
  logic             is_bus;
  op_e              op_sel;
  logic             idle;
  logic             launch;
  phase_e           ph;
  op_e              op_q;
  logic [DQ_W-1:0]  byte_q;

  always_comb begin
    is_bus = 1'b0;
    op_sel = OP_READ;
    if (host_wr && host_addr == RIX_CMD) begin
      is_bus = 1'b1;
      op_sel = OP_CMD;
    end else if (host_wr && host_addr == RIX_ADR) begin
      is_bus = 1'b1;
      op_sel = OP_ADDR;
    end else if (host_addr == RIX_DAT) begin
      is_bus = 1'b1;
      op_sel = host_wr ? OP_WRITE : OP_READ;
    end
  end

  assign cfg_we     = host_req && host_wr && (host_addr == RIX_CFG);
  assign idle       = (ph == PH_IDLE);
  assign launch     = host_req && is_bus && idle && en;
  assign host_ready = idle;

  always_comb begin
    case (host_addr)
      RIX_CFG: host_rdata = cfg_word;
      RIX_STA: host_rdata = REG_W'(rb_ready);
      default: host_rdata = '0;
    endcase
  end

  nfs_regs #(.SYNC_N(SYNC_N)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(host_wdata),
    .rb_pin   (nand_rb),
    .tim      (tim),
    .en       (en),
    .ce_n     (nand_ce_n),
    .cfg_word (cfg_word),
    .rb_ready (rb_ready)
  );

  nfs_phase #(.DQ_W(DQ_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch),
    .op_in   (op_sel),
    .byte_in (host_wdata[DQ_W-1:0]),
    .tim     (tim),
    .dq_in   (nand_dq_in),
    .phase   (ph),
    .op      (op_q),
    .byte_out(byte_q),
    .rd_valid(rd_valid),
    .rd_byte (rd_byte)
  );

  nfs_pins #(.DQ_W(DQ_W)) u_pins (
    .phase  (ph),
    .op     (op_q),
    .byte_in(byte_q),
    .cle    (nand_cle),
    .ale    (nand_ale),
    .we_n   (nand_we_n),
    .re_n   (nand_re_n),
    .dq_oe  (nand_dq_oe),
    .dq_out (nand_dq_out)
  );
endmodule

// File: rtl/nfs_checker.sv
module nfs_checker #(
  parameter int DQ_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            host_ready,
  input logic            rd_valid,
  input logic            nand_cle,
  input logic            nand_ale,
  input logic            nand_we_n,
  input logic            nand_re_n,
  input logic            nand_dq_oe,
  input logic [DQ_W-1:0] nand_dq_out
);
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe)); // R10
  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_we_n) |-> !$past(host_ready)); // R3
  AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe); // R7
  AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe); // R6
  AST_RDV_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (nand_re_n && $past(!nand_re_n))); // R7
  AST_DQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_dq_oe && $past(nand_dq_oe)) |-> $stable(nand_dq_out)); // R6
endmodule

bind nand_seq_top nfs_checker #(.DQ_W(DQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ready (host_ready),
  .rd_valid   (rd_valid),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe),
  .nand_dq_out(nand_dq_out)
);

// File: tb/test_nand_seq_top.sv
module test_nand_seq_top;
  localparam int K_CMD = 0, K_ADR = 1, K_WR = 2, K_RD = 3, K_BAD = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_wr;
  logic [2:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        host_ready, rd_valid;
  logic [7:0]  rd_byte;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out, nand_dq_in;
  logic        nand_rb;
  logic [7:0]  resp_byte;

  always #5 clk = ~clk;

  assign nand_dq_in = !nand_re_n ? resp_byte : 8'h00;

  nand_seq_top i_nand_seq_top (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .rd_valid(rd_valid), .rd_byte(rd_byte),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
    .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  typedef struct {
    int    kind;
    int    bval;
    int    su;
    int    act;
    int    hld;
    string tag;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int cur_su, cur_act, cur_hld;
  bit cur_en;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pack_rec(int k, int b, int s, int a, int h);
    return (k << 20) | (b << 12) | (s << 8) | (a << 4) | h;
  endfunction

  // monitor: rebuilds each bus cycle from the pins and compares with the queue
  int  mph = 0, m_su, m_act, m_hld, m_kind, m_dq, m_rdb;
  int  m_cle, m_ale, m_oe, m_tot, m_rdv;
  bit  m_dqbad;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mph == 3 && host_ready) begin
        int obs_k, obs_b, ek, eb;
        item_t e;
        obs_k = m_kind;
        obs_b = (m_kind == K_RD) ? m_rdb : m_dq;
        if (m_cle != ((m_kind == K_CMD) ? m_tot : 0)) obs_k = K_BAD;
        if (m_ale != ((m_kind == K_ADR) ? m_tot : 0)) obs_k = K_BAD;
        if (m_oe  != ((m_kind == K_RD) ? 0 : m_tot)) obs_k = K_BAD;
        if (m_rdv != ((m_kind == K_RD) ? 1 : 0)) obs_k = K_BAD;
        if (m_dqbad) obs_k = K_BAD;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected bus cycle", pack_rec(obs_k, obs_b, m_su, m_act, m_hld), 0);
        end else begin
          e  = exp_q.pop_front();
          ek = pack_rec(e.kind, e.bval, e.su, e.act, e.hld);
          eb = pack_rec(obs_k, obs_b, m_su, m_act, m_hld);
          chk(ek == eb, e.tag, eb, ek);
        end
        mph = 0;
      end else begin
        if (mph == 0 && !host_ready) begin
          mph = 1; m_su = 0; m_act = 0; m_hld = 0; m_kind = K_BAD; m_dq = -1;
          m_rdb = 0; m_cle = 0; m_ale = 0; m_oe = 0; m_tot = 0; m_rdv = 0; m_dqbad = 0;
        end
        if (mph != 0) begin
          m_tot++;
          m_cle += int'(nand_cle);
          m_ale += int'(nand_ale);
          m_oe  += int'(nand_dq_oe);
          if (nand_dq_oe) begin
            if (m_dq < 0) m_dq = int'(nand_dq_out);
            else if (m_dq != int'(nand_dq_out)) m_dqbad = 1;
          end
          if (rd_valid) begin
            m_rdv++;
            m_rdb = int'(rd_byte);
          end
          case (mph)
            1: begin
              if (!nand_we_n || !nand_re_n) begin
                mph = 2; m_act = 1;
                if (!nand_re_n) m_kind = K_RD;
                else if (nand_cle) m_kind = K_CMD;
                else if (nand_ale) m_kind = K_ADR;
                else m_kind = K_WR;
              end else m_su++;
            end
            2: begin
              if (!nand_we_n || !nand_re_n) m_act++;
              else begin mph = 3; m_hld = 1; end
            end
            default: m_hld++;
          endcase
        end
      end
    end
  end

  task automatic acc(input bit wr, input int a, input int d, output int rd);
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a[2:0]; host_wdata = d[15:0];
    while (!(host_ready || a == 0 || a == 4 || (wr == 1'b0 && a != 3) || a > 4)) @(negedge clk);
    rd = int'(host_rdata);
    @(posedge clk);
    #1 host_req = 1'b0;
  endtask

  task automatic cfg_wr(input int w);
    int dummy;
    acc(1'b1, 0, w, dummy);
    cur_en  = w[15];
    cur_su  = (w >> 8) & 3;
    cur_act = (w >> 4) & 7;
    cur_hld = w & 7;
  endtask

  task automatic bus(input int kind, input int val, input string tag);
    item_t it;
    int dummy;
    if (cur_en) begin
      it.kind = kind; it.bval = (kind == K_RD) ? resp_byte : val;
      it.su = cur_su + 1; it.act = cur_act + 1; it.hld = cur_hld + 1; it.tag = tag;
      exp_q.push_back(it);
    end
    case (kind)
      K_CMD:   acc(1'b1, 1, val, dummy);
      K_ADR:   acc(1'b1, 2, val, dummy);
      K_WR:    acc(1'b1, 3, val, dummy);
      default: acc(1'b0, 3, 0, dummy);
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int rd;
    bit quiet;
    rst_n = 1'b0; host_req = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
    nand_rb = 1'b1; resp_byte = 8'h00;
    cur_en = 1; cur_su = 3; cur_act = 7; cur_hld = 7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe, "R1 idle bus after reset",
        {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 5'b11000);
    chk(nand_ce_n == 1'b1 && host_ready == 1'b1 && rd_valid == 1'b0, "R1 ce_n/ready after reset",
        {nand_ce_n, host_ready, rd_valid}, 3'b110);
    acc(1'b0, 0, 0, rd);
    chk(rd == 16'h8B77, "R1 cfg reset value", rd, 16'h8B77);

    // R13 default timing
    bus(K_CMD, 8'h70, "R13 R4 default 4/8/8 command cycle");

    // R2 field layout
    cfg_wr(16'hFFFF);
    acc(1'b0, 0, 0, rd);
    chk(rd == 16'h8B77, "R2 unused cfg bits read 0", rd, 16'h8B77);
    chk(nand_ce_n == 1'b1, "R8 ce_n deselected", nand_ce_n, 1);
    cfg_wr(16'h8120);
    acc(1'b0, 0, 0, rd);
    chk(rd == 16'h8120, "R2 cfg readback", rd, 16'h8120);
    chk(nand_ce_n == 1'b0, "R8 ce_n selected", nand_ce_n, 0);

    // R3 R5 R6 R7 under 2/3/1
    bus(K_ADR, 8'h12, "R5 R3 address cycle 2/3/1");
    bus(K_WR, 8'hA5, "R6 data write cycle");
    resp_byte = 8'h3C;
    bus(K_RD, 0, "R7 data read cycle");

    // R10 stall and R11 timing change mid-cycle
    bus(K_CMD, 8'h90, "R11 in-flight cycle keeps old timing");
    @(negedge clk);
    chk(host_ready == 1'b0, "R10 busy during cycle", host_ready, 0);
    cfg_wr(16'h8005);
    chk(host_ready == 1'b0, "R10 cfg write taken while busy", host_ready, 0);
    bus(K_ADR, 8'h34, "R11 next cycle uses new timing 1/1/6");
    bus(K_WR, 8'h5A, "R10 stalled write follows after hold");

    // other timing pattern
    cfg_wr(16'h8303);
    resp_byte = 8'hC3;
    bus(K_RD, 0, "R7 R3 read cycle 4/1/4");
    bus(K_CMD, 8'hFF, "R4 command cycle 4/1/4");

    // R12 disabled controller
    repeat (30) @(negedge clk);
    cfg_wr(16'h0120);
    bus(K_CMD, 8'hFF, "R12 dropped");
    bus(K_RD, 0, "R12 dropped");
    quiet = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (!(host_ready && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && !rd_valid))
        quiet = 0;
    end
    chk(quiet, "R12 no bus activity while disabled", quiet, 1);
    cfg_wr(16'h8120);
    bus(K_WR, 8'h11, "R12 R6 write after re-enable");

    // R9 status
    nand_rb = 1'b0;
    repeat (3) @(negedge clk);
    acc(1'b0, 4, 0, rd);
    chk(rd == 0, "R9 status busy", rd, 0);
    nand_rb = 1'b1;
    repeat (3) @(negedge clk);
    acc(1'b0, 4, 0, rd);
    chk(rd == 1, "R9 status ready", rd, 1);

    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected cycles seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule